// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store that sits beside a direct-mapped cache and holds lines that cache has recently thrown out. When the direct-mapped cache misses, the line address is offered on the lookup port. Every stored tag is compared with it in the same cycle. On a hit, the stored line is handed back so the main cache can refill from it, and the memory request is not needed. The lines it holds are only discarded ones, and it exists to recover conflict misses while the main cache keeps its short hit time. The intended pairing is a 4 KB direct-mapped data cache with four buffer entries.

Lines discarded by the main cache arrive on the insert port. If a lookup hits in the same cycle, the discarded line takes the slot of the line that goes back to the main cache, which is a swap. Otherwise the line goes into a free entry. If no entry is free, it displaces the least recently written entry, and the displaced line leaves on the swap-out port. All results are registered and appear one clock after the request. A flush input empties the buffer in one cycle.

Top module: `victim_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty: rsp_valid and out_valid are 0, and a first lookup of any address misses.
- R2: A lookup (lkp_valid=1) gives rsp_valid=1 on the next clock edge. rsp_hit is 1 exactly when a valid entry holds lkp_addr, and rsp_data then carries that entry's line.
- R3: A lookup hit with no insert in the same cycle removes the entry, so a repeated lookup of that address misses.
- R4: A lookup hit together with an insert of a new address places the inserted line in the slot that hit (swap). No line leaves on the swap-out port, the inserted address hits later, and the returned address is gone.
- R5: An insert uses a free entry while one exists, and out_valid stays 0.
- R6: An insert of an address already held updates that entry's data and refreshes its recency without taking a second entry. out_valid stays 0.
- R7: An insert of a new address into a full buffer with no lookup hit raises out_valid on the next edge, with out_addr/out_data giving the displaced line.
- R8: The displaced line is the valid entry whose last insert or update is oldest (true LRU over all entries).
- R9: flush=1 clears every entry in one cycle. A lookup or insert in that cycle is dropped: no rsp_valid, no out_valid, and nothing is stored.
- R10: At most one entry ever matches a given address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lkp_valid | input | 1 | Lookup request after a main-cache miss |
| lkp_addr | input | AW | Line address looked up |
| ins_valid | input | 1 | Line discarded by the main cache |
| ins_addr | input | AW | Line address of the discarded line |
| ins_data | input | DW | Data of the discarded line |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_data | output | DW | Line data returned on a hit |
| out_valid | output | 1 | A line was displaced from the buffer |
| out_addr | output | AW | Address of the displaced line |
| out_data | output | DW | Data of the displaced line |

## Verification
The bench builds the block with N=4 entries, a 12-bit line address and 32-bit line data. The entry count matches the intended design point, so filling, displacement order and the swap all happen in short sequences. The narrow fields keep the addresses and data easy to read in failure lines. With four entries, a handful of inserts is enough to make the least-recent choice depend on refreshes, swaps and removals, which tests the recency order more than plain insertion order.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // how an incoming discarded line picks its slot
  typedef enum logic [2:0] {
    PLACE_NONE  = 3'd0,
    PLACE_DUP   = 3'd1,
    PLACE_SWAP  = 3'd2,
    PLACE_FREE  = 3'd3,
    PLACE_EVICT = 3'd4
  } place_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int N  = 4,
  parameter int AW = 26,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          valid,
  input  logic [N-1:0][AW-1:0]  tags,
  input  logic [AW-1:0]         key,
  output logic [N-1:0]          hit_vec,
  output logic                  hit,
  output logic [IW-1:0]         hit_idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign hit = |hit_vec;

  // R10: an address is never held twice
  a_r10_single_match: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec))
    else $error("R10 more than one entry matches");
endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drop_en,
  input  logic [IW-1:0] drop_idx,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);
  localparam logic [IW-1:0] OLDEST = IW'(N - 1);

  logic [N-1:0][IW-1:0] age_q, age_mid, age_nxt;

  // step 1: a removed entry becomes the oldest, the others close the gap
  always_comb begin
    age_mid = age_q;
    if (drop_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == drop_idx) age_mid[i] = OLDEST;
        else if (age_q[i] > age_q[drop_idx]) age_mid[i] = age_q[i] - 1'b1;
      end
    end
  end

  // step 2: a written entry becomes the youngest
  always_comb begin
    age_nxt = age_mid;
    if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age_nxt[i] = '0;
        else if (age_mid[i] < age_mid[touch_idx]) age_nxt[i] = age_mid[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else begin
      age_q <= age_nxt;
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == OLDEST) oldest_idx = IW'(i);
    end
  end

  // R8: ages always form a permutation, so the oldest entry is unique
  logic [N-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < N; i++) age_seen[age_q[i]] = 1'b1;
  end

  a_r8_age_permutation: assert property (@(posedge clk) disable iff (rst) &age_seen)
    else $error("R8 recency ages not distinct");
endmodule

// File: rtl/vb_data_ram.sv
module vb_data_ram #(
  parameter int N  = 4,
  parameter int DW = 256,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N];

  // one write port, one registered read port, read-before-write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int N  = 4,
  parameter int AW = 26,
  parameter int DW = 256,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          lkp_valid,
  input  logic [AW-1:0] lkp_addr,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_data,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  import vb_pkg::*;

  logic [N-1:0]         valid_q;
  logic [N-1:0][AW-1:0] tag_q;

  logic [N-1:0]  lk_vec, in_vec;
  logic          lk_match, in_match;
  logic [IW-1:0] lk_idx, in_idx;

  vb_match #(.N(N), .AW(AW)) u_lkp_match (
    .clk(clk), .rst(rst), .valid(valid_q), .tags(tag_q), .key(lkp_addr),
    .hit_vec(lk_vec), .hit(lk_match), .hit_idx(lk_idx)
  );

  vb_match #(.N(N), .AW(AW)) u_ins_match (
    .clk(clk), .rst(rst), .valid(valid_q), .tags(tag_q), .key(ins_addr),
    .hit_vec(in_vec), .hit(in_match), .hit_idx(in_idx)
  );

  // lowest free slot
  logic          any_free;
  logic [IW-1:0] free_idx;
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  logic [IW-1:0] oldest_idx;
  logic          lk_hit, wr_en, drop_en;
  logic [IW-1:0] tgt_idx;
  place_e        place;

  assign lk_hit = lkp_valid && lk_match && !flush;

  always_comb begin
    place   = PLACE_NONE;
    tgt_idx = '0;
    if (ins_valid && !flush) begin
      if (in_match) begin
        place   = PLACE_DUP;
        tgt_idx = in_idx;
      end else if (lk_hit) begin
        place   = PLACE_SWAP;
        tgt_idx = lk_idx;
      end else if (any_free) begin
        place   = PLACE_FREE;
        tgt_idx = free_idx;
      end else begin
        place   = PLACE_EVICT;
        tgt_idx = oldest_idx;
      end
    end
  end

  assign wr_en   = (place != PLACE_NONE);
  assign drop_en = lk_hit && !(wr_en && (tgt_idx == lk_idx));

  vb_lru #(.N(N)) u_lru (
    .clk(clk), .rst(rst),
    .drop_en(drop_en), .drop_idx(lk_idx),
    .touch_en(wr_en), .touch_idx(tgt_idx),
    .oldest_idx(oldest_idx)
  );

  // hit read and displacement read never coincide: one read port serves both
  logic [IW-1:0] rd_idx;
  logic [DW-1:0] ram_q;
  assign rd_idx = lk_hit ? lk_idx : oldest_idx;

  vb_data_ram #(.N(N), .DW(DW)) u_data (
    .clk(clk), .we(wr_en), .waddr(tgt_idx), .wdata(ins_data),
    .raddr(rd_idx), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && (tgt_idx == IW'(i)))       valid_q[i] <= 1'b1;
        else if (drop_en && (lk_idx == IW'(i))) valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[tgt_idx] <= ins_addr;
  end

  logic          rsp_valid_q, rsp_hit_q, out_valid_q;
  logic [AW-1:0] out_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      out_valid_q <= 1'b0;
      out_addr_q  <= '0;
    end else begin
      rsp_valid_q <= lkp_valid && !flush;
      rsp_hit_q   <= lk_hit;
      out_valid_q <= (place == PLACE_EVICT);
      out_addr_q  <= tag_q[oldest_idx];
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = ram_q;
  assign out_valid = out_valid_q;
  assign out_addr  = out_addr_q;
  assign out_data  = ram_q;

  // R2: a response only follows an accepted lookup
  a_r2_rsp_follows_lookup: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(lkp_valid && !flush))
    else $error("R2 response without lookup");

  // R9: flush leaves the buffer empty and drops the cycle's work
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (valid_q == '0) && !rsp_valid && !out_valid)
    else $error("R9 flush did not empty buffer");

  // R7: displacement only happens from a full buffer
  a_r7_evict_only_full: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(&valid_q))
    else $error("R7 displacement with a free entry");

  // R4: a swap keeps the number of held lines unchanged
  a_r4_swap_keeps_count: assert property (@(posedge clk) disable iff (rst)
    $past(place == PLACE_SWAP) |-> ($countones(valid_q) == $past($countones(valid_q))))
    else $error("R4 swap changed occupancy");

  // R6: a duplicate insert never raises occupancy
  a_r6_dup_no_alloc: assert property (@(posedge clk) disable iff (rst)
    $past(place == PLACE_DUP) |-> ($countones(valid_q) <= $past($countones(valid_q))))
    else $error("R6 duplicate allocated a new entry");
endmodule

// File: tb/test_victim_buffer.sv
module test_victim_buffer;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          flush, lkp_valid, ins_valid;
  logic [AW-1:0] lkp_addr, ins_addr;
  logic [DW-1:0] ins_data;
  logic          rsp_valid, rsp_hit, out_valid;
  logic [DW-1:0] rsp_data, out_data;
  logic [AW-1:0] out_addr;

  always #4 clk = ~clk;  // 125 MHz

  victim_buffer #(.N(N), .AW(AW), .DW(DW)) i_victim_buffer (
    .clk(clk), .rst(rst), .flush(flush),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
  );

  typedef struct {
    logic          rv, rh;
    logic [DW-1:0] rd;
    logic          ov;
    logic [AW-1:0] oa;
    logic [DW-1:0] od;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  bit            m_v [N];
  logic [AW-1:0] m_t [N];
  logic [DW-1:0] m_d [N];
  int            m_s [N];
  int            stamp = 0;

  function automatic int m_find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == a) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic op(bit fl, bit lv, logic [AW-1:0] la, bit iv, logic [AW-1:0] ia,
                    logic [DW-1:0] id, string req);
    exp_t e;
    int h, tgt;
    @(negedge clk);
    flush = fl; lkp_valid = lv; lkp_addr = la;
    ins_valid = iv; ins_addr = ia; ins_data = id;
    e = '{rv: 0, rh: 0, rd: '0, ov: 0, oa: '0, od: '0, req: req};
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      h = lv ? m_find(la) : -1;
      e.rv = lv;
      e.rh = (h >= 0);
      if (h >= 0) e.rd = m_d[h];
      tgt = -1;
      if (iv) begin
        tgt = m_find(ia);
        if (tgt < 0 && h >= 0) tgt = h;
        if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) tgt = i;
        if (tgt < 0) begin
          tgt = 0;
          for (int i = 1; i < N; i++) if (m_s[i] < m_s[tgt]) tgt = i;
          e.ov = 1; e.oa = m_t[tgt]; e.od = m_d[tgt];
        end
      end
      if (h >= 0 && h != tgt) m_v[h] = 0;
      if (iv) begin
        stamp++;
        m_v[tgt] = 1; m_t[tgt] = ia; m_d[tgt] = id; m_s[tgt] = stamp;
      end
    end
    exp_q.push_back(e);
  endtask

  task automatic idle();
    op(0, 0, '0, 0, '0, '0, "idle");
  endtask

  // monitor: compare each registered result with its expected item
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(rsp_valid == e.rv, e.req, "rsp_valid", 64'(rsp_valid), 64'(e.rv));
      if (e.rv) chk(rsp_hit == e.rh, e.req, "rsp_hit", 64'(rsp_hit), 64'(e.rh));
      if (e.rv && e.rh) chk(rsp_data == e.rd, e.req, "rsp_data", 64'(rsp_data), 64'(e.rd));
      chk(out_valid == e.ov, e.req, "out_valid", 64'(out_valid), 64'(e.ov));
      if (e.ov) begin
        chk(out_addr == e.oa, e.req, "out_addr", 64'(out_addr), 64'(e.oa));
        chk(out_data == e.od, e.req, "out_data", 64'(out_data), 64'(e.od));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_s[i] = 0; end
    rst = 1; flush = 0; lkp_valid = 0; ins_valid = 0;
    lkp_addr = '0; ins_addr = '0; ins_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(out_valid == 0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    op(0, 1, 12'h010, 0, '0, '0, "R1");

    // R5: fill free entries
    op(0, 0, '0, 1, 12'h100, 32'hA0A0_0001, "R5");
    op(0, 0, '0, 1, 12'h200, 32'hB0B0_0002, "R5");
    op(0, 0, '0, 1, 12'h300, 32'hC0C0_0003, "R5");
    // R2 hit then R3 removal
    op(0, 1, 12'h100, 0, '0, '0, "R2");
    op(0, 1, 12'h100, 0, '0, '0, "R3");
    op(0, 1, 12'h999, 0, '0, '0, "R2");
    op(0, 0, '0, 1, 12'h100, 32'hA0A0_0011, "R5");
    op(0, 0, '0, 1, 12'h400, 32'hD0D0_0004, "R5");
    // R6: duplicate refreshes B
    op(0, 0, '0, 1, 12'h200, 32'hB0B0_0022, "R6");
    // R7/R8: oldest is C, then A
    op(0, 0, '0, 1, 12'h500, 32'hE0E0_0005, "R7");
    op(0, 0, '0, 1, 12'h600, 32'hF0F0_0006, "R8");
    // R4: swap B out, G in
    op(0, 1, 12'h200, 1, 12'h700, 32'h7777_0007, "R4");
    op(0, 1, 12'h200, 0, '0, '0, "R4");
    op(0, 1, 12'h700, 0, '0, '0, "R4");
    // lookup miss and insert into a three-entry buffer, then full with miss
    op(0, 1, 12'h123, 1, 12'h800, 32'h8888_0008, "R5");
    op(0, 1, 12'h124, 1, 12'h900, 32'h9999_0009, "R7");
    op(0, 1, 12'h600, 0, '0, '0, "R2");
    idle();
    // R9: flush drops same-cycle work
    op(1, 1, 12'h500, 1, 12'hA00, 32'hAAAA_000A, "R9");
    op(0, 1, 12'h500, 0, '0, '0, "R9");
    op(0, 1, 12'hA00, 0, '0, '0, "R9");
    // R8 after flush: insertion order rules
    op(0, 0, '0, 1, 12'h011, 32'h1111_0001, "R5");
    op(0, 0, '0, 1, 12'h022, 32'h2222_0002, "R5");
    op(0, 0, '0, 1, 12'h033, 32'h3333_0003, "R5");
    op(0, 0, '0, 1, 12'h044, 32'h4444_0004, "R5");
    op(0, 0, '0, 1, 12'h011, 32'h1111_0101, "R6");
    op(0, 0, '0, 1, 12'h055, 32'h5555_0005, "R8");
    op(0, 1, 12'h011, 0, '0, '0, "R6");
    op(0, 0, '0, 1, 12'h066, 32'h6666_0006, "R5");
    op(0, 0, '0, 1, 12'h077, 32'h7777_0007, "R8");
    // R10: dup insert with lookup of same line
    op(0, 1, 12'h044, 1, 12'h044, 32'h4444_0404, "R10");
    op(0, 1, 12'h044, 0, '0, '0, "R10");
    idle();
    idle();
    @(negedge clk);
    finish_run();
  end
endmodule